// File: doc/BRIEF.md
# One-time-programmable fuse read controller

This block lets a master on a simple 32-bit register bus read single bytes out of a one-time-programmable fuse array. The master loads a 10-bit byte address, writes a start strobe to the control register and polls the status register until the ready flag rises again. The byte then sits in the data register, the read-done flag is set, and the master acknowledges by clearing the flag and scrubbing the data field with a byte-masked write.

A sequencer owns the access timing. It latches the address and the access length when a read starts, drives the array for one cycle, captures the returned byte and holds ready low for a fixed number of cycles. That number can be stretched by a small wait-state field in the configuration register. The fuse array here is a behavioural model with a fixed pipeline latency. Its contents are a computed function of the address.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, status (offset 0x00) reads 0x1 (ready in bit 0 high, done in bit 1 low). Address (0x04), data (0x08), configuration (0x0C) and control (0x14) all read 0.
- R2: The address register holds a byte address in bits 9:0 and reads it back. Bits 31:10 read 0. Byte enable 0 writes bits 7:0 and byte enable 1 writes bits 9:8.
- R3: A write to control with byte enable 0 and data bit 1 set, issued while ready is high, starts a read. Ready reads low for exactly RD_CYCLES (default 8) plus the wait count, and then ready and done rise in the same cycle.
- R4: When a read completes, data bits 7:0 hold the fuse byte at the latched address a: ((a[7:0] ^ 0xC3) + (a[9:8] << 6)) mod 256.
- R5: Writing status with byte enable 0 and data bit 1 set clears done. Writing 0 in bit 1 leaves done unchanged. A clear that lands on the completion edge loses to the set.
- R6: A write to data with byte enable 0 replaces bits 7:0 with data bits 7:0 (used to scrub the byte). A write with byte enable 0 low leaves the field unchanged.
- R7: A start issued while ready is low is ignored: the busy time is not extended. An address written during a busy period neither alters the read in flight nor its result.
- R8: A control write with bit 1 clear starts nothing. Control always reads 0.
- R9: Offsets other than 0x00, 0x04, 0x08, 0x0C and 0x14 read 0, and writes to them change no register.
- R10: Configuration bits 3:0 hold a wait count that is read back and added to the busy time of every read started afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables for writes |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the offset on addr_i (combinational) |

## Verification
The bench counts the cycles in which ready reads low, both with the wait count at zero and at five. A sequencer that is off by one edge, or one that ignores the wait field, gives the wrong count. It fires a second start and a new address in the middle of a busy period; a design that restarts would stretch the busy time or return the byte for the new address. It lands a done-clear exactly on the completion edge; giving the clear priority would lose the flag. It also writes to holes in the map and checks that the mapped registers did not change.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int unsigned FUSE_AW = 10;
  localparam int unsigned OFF_W   = 5;

  localparam logic [OFF_W-1:0] OFF_STAT = 5'h00;
  localparam logic [OFF_W-1:0] OFF_ADDR = 5'h04;
  localparam logic [OFF_W-1:0] OFF_DATA = 5'h08;
  localparam logic [OFF_W-1:0] OFF_CFG  = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_CTRL = 5'h14;

  localparam int unsigned STAT_RDY  = 0;
  localparam int unsigned STAT_DONE = 1;
  localparam int unsigned CTRL_GO   = 1;

  // behavioural fuse contents
  function automatic logic [7:0] fuse_byte(input logic [FUSE_AW-1:0] a);
    return (a[7:0] ^ 8'hC3) + {a[9:8], 6'b0};
  endfunction
endpackage

// File: rtl/fuse_rd_array.sv
module fuse_rd_array
  import fuse_rd_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic [FUSE_AW-1:0] addr_i,
  output logic               vld_o,
  output logic [7:0]         data_o
);
  logic [LAT-1:0] vld_q;
  logic [7:0]     dat_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q[0] <= 1'b0;
      dat_q[0] <= '0;
    end else begin
      vld_q[0] <= rd_i;
      dat_q[0] <= rd_i ? fuse_byte(addr_i) : 8'h00;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        dat_q[s] <= '0;
      end else begin
        vld_q[s] <= vld_q[s-1];
        dat_q[s] <= dat_q[s-1];
      end
    end
  end

  assign vld_o  = vld_q[LAT-1];
  assign data_o = dat_q[LAT-1];
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int unsigned RD_CYCLES = 8,
  parameter int unsigned CFG_W     = 4,
  parameter int unsigned LAT       = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FUSE_AW-1:0] addr_i,
  input  logic [CFG_W-1:0]   wait_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [7:0]         data_o,
  output logic [FUSE_AW-1:0] lat_addr_o
);
  localparam int unsigned MAX_LEN = RD_CYCLES + (1 << CFG_W) - 1;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q, len_q;
  logic [FUSE_AW-1:0] addr_q;
  logic [7:0]         cap_q;
  logic               arr_rd, arr_vld, last;
  logic [7:0]         arr_data;

  assign arr_rd = busy_q && (cnt_q == '0);
  assign last   = busy_q && (cnt_q == len_q - CNT_W'(1));

  fuse_rd_array #(.LAT(LAT)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (arr_rd),
    .addr_i (addr_q),
    .vld_o  (arr_vld),
    .data_o (arr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        len_q  <= CNT_W'(RD_CYCLES) + CNT_W'(wait_i);
        addr_q <= addr_i;
      end
    end else if (last) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= '0;
    else if (arr_vld) cap_q <= arr_data;
  end

  assign ready_o    = !busy_q;
  assign done_o     = last;
  assign data_o     = cap_q;
  assign lat_addr_o = addr_q;
endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int unsigned CFG_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [3:0]         be_i,
  input  logic [OFF_W-1:0]   addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               ready_i,
  input  logic               done_set_i,
  input  logic [7:0]         ld_data_i,
  output logic               start_o,
  output logic [FUSE_AW-1:0] addr_o,
  output logic [CFG_W-1:0]   wait_o,
  output logic               done_o,
  output logic [7:0]         data_o
);
  logic               wr;
  logic [FUSE_AW-1:0] addr_q;
  logic [CFG_W-1:0]   cfg_q;
  logic               done_q;
  logic [7:0]         data_q;

  assign wr      = req_i && we_i;
  assign start_o = wr && (addr_i == OFF_CTRL) && be_i[0] && wdata_i[CTRL_GO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cfg_q  <= '0;
    end else if (wr) begin
      if (addr_i == OFF_ADDR) begin
        if (be_i[0]) addr_q[7:0] <= wdata_i[7:0];
        if (be_i[1]) addr_q[FUSE_AW-1:8] <= wdata_i[FUSE_AW-1:8];
      end
      if (addr_i == OFF_CFG && be_i[0]) cfg_q <= wdata_i[CFG_W-1:0];
    end
  end

  // completion wins over a same-cycle clear or scrub
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (done_set_i) done_q <= 1'b1;
      else if (wr && addr_i == OFF_STAT && be_i[0] && wdata_i[STAT_DONE]) done_q <= 1'b0;
      if (done_set_i) data_q <= ld_data_i;
      else if (wr && addr_i == OFF_DATA && be_i[0]) data_q <= wdata_i[7:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_STAT: begin
        rdata_o[STAT_RDY]  = ready_i;
        rdata_o[STAT_DONE] = done_q;
      end
      OFF_ADDR: rdata_o[FUSE_AW-1:0] = addr_q;
      OFF_DATA: rdata_o[7:0]         = data_q;
      OFF_CFG:  rdata_o[CFG_W-1:0]   = cfg_q;
      default:  rdata_o = '0;
    endcase
  end

  assign addr_o = addr_q;
  assign wait_o = cfg_q;
  assign done_o = done_q;
  assign data_o = data_q;
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int unsigned RD_CYCLES = 8,
  parameter int unsigned CFG_W     = 4,
  parameter int unsigned ARR_LAT   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [3:0]       be_i,
  input  logic [OFF_W-1:0] addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic               start, ready, done_set, done;
  logic [FUSE_AW-1:0] reg_addr, lat_addr;
  logic [CFG_W-1:0]   cfg_wait;
  logic [7:0]         seq_data, data_val;

  fuse_rd_regs #(.CFG_W(CFG_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .be_i       (be_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .ready_i    (ready),
    .done_set_i (done_set),
    .ld_data_i  (seq_data),
    .start_o    (start),
    .addr_o     (reg_addr),
    .wait_o     (cfg_wait),
    .done_o     (done),
    .data_o     (data_val)
  );

  fuse_rd_seq #(.RD_CYCLES(RD_CYCLES), .CFG_W(CFG_W), .LAT(ARR_LAT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_i     (reg_addr),
    .wait_i     (cfg_wait),
    .ready_o    (ready),
    .done_o     (done_set),
    .data_o     (seq_data),
    .lat_addr_o (lat_addr)
  );
endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
module fuse_rd_ctrl_chk
  import fuse_rd_pkg::*;
#(
  parameter int unsigned RD_CYCLES = 8,
  parameter int unsigned CFG_W     = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [OFF_W-1:0]   addr_i,
  input logic [31:0]        rdata_o,
  input logic               start,
  input logic               ready,
  input logic               done,
  input logic [CFG_W-1:0]   cfg_wait,
  input logic [FUSE_AW-1:0] lat_addr,
  input logic [7:0]         data_val
);
  logic [15:0] low_cnt, len_q;
  logic        mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      len_q   <= '0;
    end else begin
      low_cnt <= ready ? 16'd0 : low_cnt + 16'd1;
      if (!ready && low_cnt == 16'd0) len_q <= 16'(RD_CYCLES) + 16'(cfg_wait);
    end
  end

  assign mapped = addr_i inside {OFF_STAT, OFF_ADDR, OFF_DATA, OFF_CFG, OFF_CTRL};

  assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) |-> low_cnt == len_q);
  assert_start_drops_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && ready) |=> !ready);
  assert_done_with_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) |-> done);
  assert_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) |-> data_val == fuse_byte(lat_addr));
  assert_done_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $rose(ready));
  assert_addr_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready && $past(!ready)) |-> $stable(lat_addr));
  assert_hole_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |-> rdata_o == 32'h0);
endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(.RD_CYCLES(RD_CYCLES), .CFG_W(CFG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .start    (start),
  .ready    (ready),
  .done     (done),
  .cfg_wait (cfg_wait),
  .lat_addr (lat_addr),
  .data_val (data_val)
);

// File: tb/tb_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module tb_fuse_rd_ctrl;
  localparam int RD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  be = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit sb_on = 1'b0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  fuse_rd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] model_byte(input logic [9:0] a);
    return (a[7:0] ^ 8'hC3) + {a[9:8], 6'b0};
  endfunction

  // monitor: compare scoreboard reads
  always @(negedge clk) begin
    if (sb_on && req && !we && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h exp %h", it.tag, rdata, it.exp);
      end
    end
  end

  // all tasks are entered just after a rising edge
  task automatic bus_wr(input logic [4:0] o, input logic [31:0] d, input logic [3:0] b);
    req = 1'b1; we = 1'b1; addr = o; wdata = d; be = b;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic rd_exp(input logic [4:0] o, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    sb_on = 1'b1; req = 1'b1; we = 1'b0; addr = o;
    @(posedge clk); #1;
    req = 1'b0; sb_on = 1'b0;
  endtask

  task automatic rd_raw(input logic [4:0] o, output logic [31:0] v);
    req = 1'b1; we = 1'b0; addr = o;
    @(negedge clk); v = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  // start a read and count status polls with ready low
  task automatic run_read(input int exp_len, input string tag);
    logic [31:0] v;
    int low = 0;
    bus_wr(5'h14, 32'h2, 4'h1);
    for (int i = 0; i < 200; i++) begin
      rd_raw(5'h00, v);
      if (v[0]) break;
      low++;
    end
    check(low == exp_len, tag, low, exp_len);
    check(v[1:0] == 2'b11, {tag, " ready+done"}, v[1:0], 3);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state, R8 control reads zero
    rd_exp(5'h00, 32'h1, "R1 status");
    rd_exp(5'h04, 32'h0, "R1 addr");
    rd_exp(5'h08, 32'h0, "R1 data");
    rd_exp(5'h0C, 32'h0, "R1 cfg");
    rd_exp(5'h14, 32'h0, "R8 ctrl");

    // R2 address width and byte enables
    bus_wr(5'h04, 32'hFFFF_FFFF, 4'hF);
    rd_exp(5'h04, 32'h3FF, "R2 full");
    bus_wr(5'h04, 32'h0, 4'h1);
    rd_exp(5'h04, 32'h300, "R2 be0");
    bus_wr(5'h04, 32'h0, 4'h2);
    rd_exp(5'h04, 32'h0, "R2 be1");

    // R3/R4 basic read
    bus_wr(5'h04, 32'h123, 4'h3);
    run_read(RD, "R3 len8");
    rd_exp(5'h08, {24'h0, model_byte(10'h123)}, "R4 byte 0x123");

    // R5 done clear
    bus_wr(5'h00, 32'h0, 4'h1);
    rd_exp(5'h00, 32'h3, "R5 write0 keeps done");
    bus_wr(5'h00, 32'h2, 4'h1);
    rd_exp(5'h00, 32'h1, "R5 w1c");

    // R6 scrub
    bus_wr(5'h08, 32'h0, 4'hE);
    rd_exp(5'h08, {24'h0, model_byte(10'h123)}, "R6 no be0");
    bus_wr(5'h08, 32'h0, 4'h1);
    rd_exp(5'h08, 32'h0, "R6 scrub");

    // R10 wait states
    bus_wr(5'h0C, 32'h5, 4'h1);
    rd_exp(5'h0C, 32'h5, "R10 cfg rb");
    bus_wr(5'h04, 32'h3FF, 4'h3);
    run_read(RD + 5, "R10 len13");
    rd_exp(5'h08, {24'h0, model_byte(10'h3FF)}, "R4 byte 0x3FF");
    bus_wr(5'h0C, 32'h0, 4'h1);
    bus_wr(5'h00, 32'h2, 4'h1);

    // R7 start and address change while busy
    begin
      logic [31:0] v;
      int low = 2;
      bus_wr(5'h04, 32'h040, 4'h3);
      bus_wr(5'h14, 32'h2, 4'h1);        // lands at edge E
      bus_wr(5'h04, 32'h2AA, 4'h3);      // E+1
      bus_wr(5'h14, 32'h2, 4'h1);        // E+2, ignored
      for (int i = 0; i < 200; i++) begin
        rd_raw(5'h00, v);
        if (v[0]) break;
        low++;
      end
      check(low == RD, "R7 len kept", low, RD);
      rd_exp(5'h08, {24'h0, model_byte(10'h040)}, "R7 old addr byte");
      rd_exp(5'h04, 32'h2AA, "R7 addr rb");
    end

    // R5 set wins over clear on completion edge
    bus_wr(5'h00, 32'h2, 4'h1);
    bus_wr(5'h04, 32'h011, 4'h3);
    bus_wr(5'h14, 32'h2, 4'h1);          // lands E
    repeat (RD - 1) @(posedge clk);
    #1;
    bus_wr(5'h00, 32'h2, 4'h1);          // lands E+RD
    rd_exp(5'h00, 32'h3, "R5 set beats clear");
    rd_exp(5'h08, {24'h0, model_byte(10'h011)}, "R4 byte 0x011");

    // R8 control write without go bit
    bus_wr(5'h00, 32'h2, 4'h1);
    bus_wr(5'h14, 32'h1, 4'h1);
    rd_exp(5'h00, 32'h1, "R8 no start");
    bus_wr(5'h14, 32'h2, 4'h2);
    rd_exp(5'h00, 32'h1, "R8 no be0 no start");

    // R9 holes
    bus_wr(5'h10, 32'hFFFF_FFFF, 4'hF);
    bus_wr(5'h18, 32'hFFFF_FFFF, 4'hF);
    bus_wr(5'h1C, 32'hFFFF_FFFF, 4'hF);
    bus_wr(5'h05, 32'hFFFF_FFFF, 4'hF);
    rd_exp(5'h10, 32'h0, "R9 0x10");
    rd_exp(5'h18, 32'h0, "R9 0x18");
    rd_exp(5'h05, 32'h0, "R9 0x05");
    rd_exp(5'h04, 32'h011, "R9 addr kept");
    rd_exp(5'h0C, 32'h0, "R9 cfg kept");
    rd_exp(5'h08, {24'h0, model_byte(10'h011)}, "R9 data kept");
    rd_exp(5'h00, 32'h1, "R9 status kept");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: got %0d left exp 0", sb.size());
    end
    finish_run();
  end
endmodule